// File: doc/BRIEF.md
# Cascadable Column Data Shift Loader

This block gathers one display line of 6-bit gray codes into a wide column register that a source driver's conversion stage reads later. Each clock carries six codes, which is two RGB pixels, on a 36-bit bus. A one-hot group pointer selects the six adjacent columns that the current bus word fills. The pointer is armed by a start pulse and advances one group per clock. After a fixed number of clocks the block re-emits the start pulse on its far side, so several identical chips can be chained along one line.

The fill direction can be reversed. When it is, the start input and the start output trade pins, so the same chain works when it is mounted mirrored. Two controls invert the lower three codes and the upper three codes of the bus as they are stored. A channel-count select shortens the line. In reduced mode the pointer jumps over a middle band of sixty columns, and those columns keep what they held before. A strobe rising edge clears the pointer and ends any loading in progress.

Top module: `line_col_loader`

## Requirements
- R1: While reset is held low and directly after it is released, every bit of `colData` is 0 and both start outputs are low.
- R2: A line starts at the first rising clock edge where the selected start input is high after having been low. A level that stays high for several clocks counts only once. The bus word on the start edge is not stored, and the first group is stored on the next edge.
- R3: Column c, numbered from 1 to 480, occupies `colData[6(c-1)+5 : 6(c-1)]`. Bus code k, with k from 0 to 5 and held in bits `[6k+5:6k]` (bit 0 is the LSB), goes to column 6g+k+1 of group g, where g runs from 0 to 79. With `shiftRight` high, the n-th clock after the start edge fills group n-1. With it low, that clock fills group 80-n, so columns 475 to 480 are filled first and column 475 receives bus code 0. Direction and channel select are taken at the start edge.
- R4: With `shiftRight` high, `startRightIn` is the start input, `startLeftOut` is the start output, and `startRightOut` stays low. With `shiftRight` low, the roles swap. The two outputs are never high together.
- R5: The start output is high for exactly one clock cycle. That cycle follows the 80th rising edge after the start edge when `fullWidth` is high, or the 70th when it is low. At all other times the output is low.
- R6: Once the last group of the line has been stored, bus data on later clocks is not stored until a new start edge. The line's internal activity ends 82 clocks after the start edge, or 72 clocks in reduced mode.
- R7: When `invLow` is high, codes 0 to 2 are stored bitwise inverted. When `invHigh` is high, codes 3 to 5 are stored bitwise inverted. Both controls are sampled on the same edge as the data word they affect.
- R8: With `fullWidth` low, the ten groups that hold columns 211 to 270 are skipped, and 70 groups are loaded. Those sixty columns keep their previous contents.
- R9: A new start edge while a line is loading restarts the fill from the first group. The start output timing is then counted from the new start edge.
- R10: A `strobe` rising edge, meaning strobe is sampled high after having been low, clears the pointer. The word on that edge and on every later edge is not stored until a new start edge, and no start output pulse follows. A strobe edge takes priority over a start edge on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startRightIn | input | 1 | Start pulse in on the right side, used when shiftRight is high |
| startLeftIn | input | 1 | Start pulse in on the left side, used when shiftRight is low |
| startRightOut | output | 1 | Cascade start pulse out on the right side, used when shifting left |
| startLeftOut | output | 1 | Cascade start pulse out on the left side, used when shifting right |
| shiftRight | input | 1 | Fill direction: 1 fills from column 1 upward, 0 fills from the last column downward |
| invLow | input | 1 | Invert bus codes 0 to 2 on store |
| invHigh | input | 1 | Invert bus codes 3 to 5 on store |
| fullWidth | input | 1 | 1 selects 480 columns, 0 selects 420 columns |
| strobe | input | 1 | Line strobe; its rising edge clears the pointer |
| busData | input | 36 | Six 6-bit gray codes |
| colData | output | 2880 | Full column register, 6 bits per column |

## Verification
Take the start edge as edge 0. The word driven before edge n, for n of 1 or more, lands in `colData` directly after edge n. The start output rises after edge 80, or after edge 70 in reduced mode, and falls after the next edge. Inputs therefore change at falling edges. Each pulse check is made at the falling edge that follows the edge it concerns, so after every edge the bench knows which edge count it is checking. The column contents are compared once per line, at a falling edge well past the stop count. By then a late or stray store would already have overwritten the expected model.

// File: rtl/line_col_pkg.sv
package line_col_pkg;

  // Strobes that the control hands to the datapath each clock
  typedef struct packed {
    logic loadEn;    // store the bus word into the selected group
    logic flipLow;   // invert the lower half of the codes
    logic flipHigh;  // invert the upper half of the codes
  } loadCtl_t;

endpackage

// File: rtl/line_col_ctrl.sv
module line_col_ctrl
  import line_col_pkg::*;
#(
  parameter int GROUPS      = 80,
  parameter int SKIP_FIRST  = 35,
  parameter int SKIP_GROUPS = 10,
  parameter int TAIL_CLKS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRightIn,
  input  logic              startLeftIn,
  input  logic              shiftRight,
  input  logic              fullWidth,
  input  logic              invLow,
  input  logic              invHigh,
  input  logic              strobe,
  output loadCtl_t          ctl,
  output logic [GROUPS-1:0] groupSel,
  output logic              startRightOut,
  output logic              startLeftOut
);

  localparam int SKIP_END = SKIP_FIRST + SKIP_GROUPS;
  localparam int CNT_W    = $clog2(GROUPS + TAIL_CLKS + 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(GROUPS);
  localparam logic [CNT_W-1:0] RED_LAST  = CNT_W'(GROUPS - SKIP_GROUPS);
  localparam logic [CNT_W-1:0] FULL_STOP = CNT_W'(GROUPS + TAIL_CLKS);
  localparam logic [CNT_W-1:0] RED_STOP  = CNT_W'(GROUPS - SKIP_GROUPS + TAIL_CLKS);

  logic startSel, startPrev, strobePrev, startHit, strobeRise;
  logic busy, dirQ, fullQ, pulseQ;
  logic [CNT_W-1:0] stepCnt, stepNext, lastStep, stopStep;
  logic [GROUPS-1:0] ptr, fwdNext, bwdNext, ptrNext, firstPtr;

  assign startSel   = shiftRight ? startRightIn : startLeftIn;
  assign startHit   = startSel & ~startPrev;
  assign strobeRise = strobe & ~strobePrev;

  assign lastStep = fullQ ? FULL_LAST : RED_LAST;
  assign stopStep = fullQ ? FULL_STOP : RED_STOP;
  assign stepNext = stepCnt + 1'b1;

  assign firstPtr = shiftRight ? GROUPS'(1) : {1'b1, {(GROUPS-1){1'b0}}};

  // Next pointer for each direction; the middle band is bypassed in reduced mode
  for (genvar g = 0; g < GROUPS; g++) begin : gNext
    if (g == 0) begin : gFwdHead
      assign fwdNext[g] = 1'b0;
    end else if (g >= SKIP_FIRST && g < SKIP_END) begin : gFwdBand
      assign fwdNext[g] = fullQ & ptr[g-1];
    end else if (g == SKIP_END) begin : gFwdJump
      assign fwdNext[g] = fullQ ? ptr[g-1] : ptr[SKIP_FIRST-1];
    end else begin : gFwdPlain
      assign fwdNext[g] = ptr[g-1];
    end

    if (g == GROUPS-1) begin : gBwdHead
      assign bwdNext[g] = 1'b0;
    end else if (g >= SKIP_FIRST && g < SKIP_END) begin : gBwdBand
      assign bwdNext[g] = fullQ & ptr[g+1];
    end else if (g == SKIP_FIRST-1) begin : gBwdJump
      assign bwdNext[g] = fullQ ? ptr[g+1] : ptr[SKIP_END];
    end else begin : gBwdPlain
      assign bwdNext[g] = ptr[g+1];
    end
  end

  assign ptrNext = dirQ ? fwdNext : bwdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPrev  <= 1'b0;
      strobePrev <= 1'b0;
    end else begin
      startPrev  <= startSel;
      strobePrev <= strobe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      busy    <= 1'b0;
      stepCnt <= '0;
      dirQ    <= 1'b1;
      fullQ   <= 1'b1;
      pulseQ  <= 1'b0;
    end else if (strobeRise) begin
      ptr     <= '0;
      busy    <= 1'b0;
      stepCnt <= '0;
      pulseQ  <= 1'b0;
    end else if (startHit) begin
      ptr     <= firstPtr;
      busy    <= 1'b1;
      stepCnt <= '0;
      dirQ    <= shiftRight;
      fullQ   <= fullWidth;
      pulseQ  <= 1'b0;
    end else if (busy) begin
      ptr     <= ptrNext;
      stepCnt <= stepNext;
      pulseQ  <= (stepNext == lastStep);
      if (stepNext == stopStep) busy <= 1'b0;
    end else begin
      pulseQ  <= 1'b0;
    end
  end

  always_comb begin
    ctl.loadEn   = (|ptr) & ~startHit & ~strobeRise;
    ctl.flipLow  = invLow;
    ctl.flipHigh = invHigh;
  end

  assign groupSel      = ptr;
  assign startRightOut = pulseQ & ~dirQ;
  assign startLeftOut  = pulseQ & dirQ;

endmodule

// File: rtl/line_col_datapath.sv
module line_col_datapath
  import line_col_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int CODES  = 6,
  parameter int GROUPS = 80
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  loadCtl_t                         ctl,
  input  logic [GROUPS-1:0]                groupSel,
  input  logic [CODE_W*CODES-1:0]          busData,
  output logic [GROUPS*CODE_W*CODES-1:0]   colData
);

  localparam int GW   = CODE_W * CODES;
  localparam int HALF = CODES / 2;

  logic [GW-1:0] storeWord;

  for (genvar k = 0; k < CODES; k++) begin : gFlip
    if (k < HALF) begin : gLow
      assign storeWord[k*CODE_W +: CODE_W] =
        busData[k*CODE_W +: CODE_W] ^ {CODE_W{ctl.flipLow}};
    end else begin : gHigh
      assign storeWord[k*CODE_W +: CODE_W] =
        busData[k*CODE_W +: CODE_W] ^ {CODE_W{ctl.flipHigh}};
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        colData[g*GW +: GW] <= '0;
      end else if (ctl.loadEn && groupSel[g]) begin
        colData[g*GW +: GW] <= storeWord;
      end
    end
  end

endmodule

// File: rtl/line_col_loader.sv
module line_col_loader
  import line_col_pkg::*;
#(
  parameter int CODE_W         = 6,
  parameter int CODES          = 6,
  parameter int NUM_COLS       = 480,
  parameter int SKIP_START_COL = 211,
  parameter int SKIP_COLS      = 60,
  parameter int TAIL_CLKS      = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startRightIn,
  input  logic                         startLeftIn,
  output logic                         startRightOut,
  output logic                         startLeftOut,
  input  logic                         shiftRight,
  input  logic                         invLow,
  input  logic                         invHigh,
  input  logic                         fullWidth,
  input  logic                         strobe,
  input  logic [CODE_W*CODES-1:0]      busData,
  output logic [NUM_COLS*CODE_W-1:0]   colData
);

  localparam int GROUPS      = NUM_COLS / CODES;
  localparam int SKIP_FIRST  = (SKIP_START_COL - 1) / CODES;
  localparam int SKIP_GROUPS = SKIP_COLS / CODES;
  localparam int COL_W       = NUM_COLS * CODE_W;

  loadCtl_t          ctl;
  logic [GROUPS-1:0] groupSel;

  line_col_ctrl #(
    .GROUPS(GROUPS), .SKIP_FIRST(SKIP_FIRST),
    .SKIP_GROUPS(SKIP_GROUPS), .TAIL_CLKS(TAIL_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startRightIn(startRightIn), .startLeftIn(startLeftIn),
    .shiftRight(shiftRight), .fullWidth(fullWidth),
    .invLow(invLow), .invHigh(invHigh), .strobe(strobe),
    .ctl(ctl), .groupSel(groupSel),
    .startRightOut(startRightOut), .startLeftOut(startLeftOut)
  );

  line_col_datapath #(
    .CODE_W(CODE_W), .CODES(CODES), .GROUPS(GROUPS)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .groupSel(groupSel),
    .busData(busData), .colData(colData)
  );

endmodule

// File: rtl/line_col_loader_chk.sv
module line_col_loader_chk #(
  parameter int GROUPS     = 80,
  parameter int RED_GROUPS = 70,
  parameter int COL_W      = 2880
) (
  input logic             clk,
  input logic             rstN,
  input logic             startRightIn,
  input logic             startLeftIn,
  input logic             shiftRight,
  input logic             strobe,
  input logic             startRightOut,
  input logic             startLeftOut,
  input logic [COL_W-1:0] colData
);

  localparam int CW = $clog2(GROUPS + 3) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic startQ, strobeQ, dirAtStart, hit, strobeRise;
  logic [CW-1:0] sinceStart;

  assign hit        = (shiftRight ? startRightIn : startLeftIn) & ~startQ;
  assign strobeRise = strobe & ~strobeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ     <= 1'b0;
      strobeQ    <= 1'b0;
      dirAtStart <= 1'b1;
      sinceStart <= SAT;
    end else begin
      startQ  <= shiftRight ? startRightIn : startLeftIn;
      strobeQ <= strobe;
      if (strobeRise) begin
        sinceStart <= SAT;
      end else if (hit) begin
        sinceStart <= '0;
        dirAtStart <= shiftRight;
      end else if (sinceStart != SAT) begin
        sinceStart <= sinceStart + 1'b1;
      end
    end
  end

  // R4: never both start outputs at once
  a_r4_one_pin: assert property (@(posedge clk) disable iff (!rstN)
    !(startRightOut && startLeftOut));

  // R4: pulse leaves on the side opposite the input of its line
  a_r4_left_side: assert property (@(posedge clk) disable iff (!rstN)
    startLeftOut |-> dirAtStart);

  a_r4_right_side: assert property (@(posedge clk) disable iff (!rstN)
    startRightOut |-> !dirAtStart);

  // R5: pulse only at the terminal step count
  a_r5_pulse_step: assert property (@(posedge clk) disable iff (!rstN)
    (startRightOut || startLeftOut) |->
      (sinceStart == CW'(GROUPS) || sinceStart == CW'(RED_GROUPS)));

  // R5: pulse lasts a single cycle
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (startRightOut || startLeftOut) |=> !(startRightOut || startLeftOut));

  // R6: no stores once the line's groups are used up
  a_r6_frozen_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    (sinceStart >= CW'(GROUPS)) |=> $stable(colData));

  // R10: the strobe edge stores nothing
  a_r10_strobe_no_store: assert property (@(posedge clk) disable iff (!rstN)
    strobeRise |=> $stable(colData));

endmodule

bind line_col_loader line_col_loader_chk #(
  .GROUPS(GROUPS), .RED_GROUPS(GROUPS - SKIP_GROUPS), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .startRightIn(startRightIn), .startLeftIn(startLeftIn),
  .shiftRight(shiftRight), .strobe(strobe),
  .startRightOut(startRightOut), .startLeftOut(startLeftOut),
  .colData(colData)
);

// File: tb/line_col_loader_bench.sv
module line_col_loader_bench;

  localparam int COLS   = 480;
  localparam int GROUPS = 80;
  localparam int RED    = 70;
  localparam int SKIP0  = 35;
  localparam int SKIPN  = 10;
  localparam int RUN    = 90;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startRightIn = 1'b0, startLeftIn = 1'b0;
  logic startRightOut, startLeftOut;
  logic shiftRight = 1'b1, invLow = 1'b0, invHigh = 1'b0;
  logic fullWidth = 1'b1, strobe = 1'b0;
  logic [35:0] busData = '0;
  logic [COLS*6-1:0] colData;

  int checks = 0;
  int fails  = 0;
  logic [5:0] expCols [COLS];

  always #10 clk = ~clk;

  line_col_loader u_line_col_loader (
    .clk(clk), .rstN(rstN),
    .startRightIn(startRightIn), .startLeftIn(startLeftIn),
    .startRightOut(startRightOut), .startLeftOut(startLeftOut),
    .shiftRight(shiftRight), .invLow(invLow), .invHigh(invHigh),
    .fullWidth(fullWidth), .strobe(strobe),
    .busData(busData), .colData(colData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkCols(input string req);
    int bad = 0;
    int firstC = -1;
    for (int c = 0; c < COLS; c++) begin
      if (colData[c*6 +: 6] !== expCols[c]) begin
        if (firstC < 0) firstC = c;
        bad++;
      end
    end
    if (firstC < 0)
      check(1'b1, req, "columns", 0, 0);
    else
      check(1'b0, req, $sformatf("column %0d (%0d mismatches)", firstC + 1, bad),
            int'(colData[firstC*6 +: 6]), int'(expCols[firstC]));
  endtask

  // R3/R8: group filled by the n-th clock after the start edge
  function automatic int groupFor(input int step, input bit dirR, input bit fullM);
    int j = step - 1;
    if (!fullM && j >= SKIP0) j += SKIPN;
    return dirR ? j : GROUPS - 1 - j;
  endfunction

  function automatic logic [5:0] pat(input int seed, input int step, input int k);
    return 6'((seed * 7 + step * 5 + k * 11 + seed * step) & 63);
  endfunction

  task automatic checkPulse(input bit expHigh, input bit dirR, input int edgeNo);
    logic outPin = dirR ? startLeftOut : startRightOut;
    logic other  = dirR ? startRightOut : startLeftOut;
    check(outPin === expHigh, "R5", $sformatf("start out after edge %0d", edgeNo),
          int'(outPin), int'(expHigh));
    check(other === 1'b0, "R4", $sformatf("idle side pin after edge %0d", edgeNo),
          int'(other), 0);
  endtask

  task automatic driveWord(input int seed, input int step, input bit lo, input bit hi);
    invLow  = lo;
    invHigh = hi;
    for (int k = 0; k < 6; k++) busData[k*6 +: 6] = pat(seed, step, k);
  endtask

  task automatic storeExp(input int seed, input int step, input int grp,
                          input bit lo, input bit hi);
    for (int k = 0; k < 6; k++) begin
      logic m = (k < 3) ? lo : hi;
      expCols[grp*6 + k] = pat(seed, step, k) ^ {6{m}};
    end
  endtask

  task automatic runLine(input bit dirR, input bit fullM, input int hold,
                         input int seed, input bit invMode, input string req);
    int last = fullM ? GROUPS : RED;
    @(negedge clk);
    shiftRight = dirR;
    fullWidth  = fullM;
    if (dirR) startRightIn = 1'b1; else startLeftIn = 1'b1;
    busData = '1;  // start-edge word, never stored (R2)
    invLow = 1'b0; invHigh = 1'b0;
    for (int i = 1; i <= RUN; i++) begin
      bit lo, hi;
      @(negedge clk);
      if (i >= hold) begin startRightIn = 1'b0; startLeftIn = 1'b0; end
      if (i >= 2) checkPulse(i - 1 == last, dirR, i - 1);
      lo = invMode & i[0];
      hi = invMode & i[1];
      driveWord(seed, i, lo, hi);
      if (i <= last) storeExp(seed, i, groupFor(i, dirR, fullM), lo, hi);
    end
    @(negedge clk);
    checkPulse(1'b0, dirR, RUN);
    invLow = 1'b0; invHigh = 1'b0;
    checkCols(req);
  endtask

  task automatic testReset();
    for (int c = 0; c < COLS; c++) expCols[c] = '0;
    @(negedge clk);
    checkCols("R1");
    check(startRightOut === 1'b0, "R1", "startRightOut", int'(startRightOut), 0);
    check(startLeftOut === 1'b0, "R1", "startLeftOut", int'(startLeftOut), 0);
  endtask

  task automatic testFullRight();  runLine(1'b1, 1'b1, 1, 3, 1'b0, "R3 R6 right");  endtask
  task automatic testFullLeft();   runLine(1'b0, 1'b1, 1, 5, 1'b0, "R3 R4 left");   endtask
  task automatic testRedRight();   runLine(1'b1, 1'b0, 1, 9, 1'b0, "R8 right");     endtask
  task automatic testRedLeft();    runLine(1'b0, 1'b0, 1, 12, 1'b0, "R8 left");     endtask
  task automatic testInvert();     runLine(1'b1, 1'b1, 1, 17, 1'b1, "R7");          endtask
  task automatic testHeldStart();  runLine(1'b0, 1'b1, 5, 21, 1'b0, "R2 held");     endtask

  // R9: restart ten groups into a line
  task automatic testRestart();
    @(negedge clk);
    shiftRight = 1'b1; fullWidth = 1'b1; startRightIn = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      startRightIn = 1'b0;
      driveWord(25, i, 1'b0, 1'b0);
      storeExp(25, i, groupFor(i, 1'b1, 1'b1), 1'b0, 1'b0);
    end
    runLine(1'b1, 1'b1, 1, 29, 1'b0, "R9");
  endtask

  // R10: strobe mid-line stops storing and suppresses the pulse
  task automatic testStrobe();
    @(negedge clk);
    shiftRight = 1'b1; fullWidth = 1'b1; startRightIn = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      startRightIn = 1'b0;
      driveWord(33, i, 1'b0, 1'b0);
      storeExp(33, i, groupFor(i, 1'b1, 1'b1), 1'b0, 1'b0);
    end
    @(negedge clk);
    strobe = 1'b1;
    driveWord(33, 6, 1'b0, 1'b0);
    @(negedge clk);
    driveWord(33, 7, 1'b0, 1'b0);
    @(negedge clk);
    strobe = 1'b0;
    for (int i = 8; i <= RUN; i++) begin
      @(negedge clk);
      driveWord(33, i, 1'b0, 1'b0);
      check(startLeftOut === 1'b0 && startRightOut === 1'b0, "R10",
            $sformatf("no pulse at step %0d", i),
            int'(startLeftOut | startRightOut), 0);
    end
    @(negedge clk);
    checkCols("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFullRight();
    testFullLeft();
    testRedRight();
    testRedLeft();
    testInvert();
    testHeldStart();
    testRestart();
    testStrobe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule